// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between the byte-level protocol engine of a two-wire serial memory slave and its byte-wide storage array. It gathers the data bytes of one write transaction into a sixteen-slot page buffer and then commits them in a self-timed program cycle. The protocol engine tells it when a transaction opens (with the starting 11-bit address), when each data byte arrives, and when the closing STOP is seen. A write-protect pin can veto the whole commit.

The starting address splits in two. The upper seven bits name the page and the lower four bits name the first buffer slot. Each new byte goes to the next slot, and the slot index wraps from 15 back to 0 inside the same page. More than sixteen bytes therefore overwrite the oldest ones, so only the last sixteen survive. After a qualifying STOP the block raises `busy`, which the protocol engine uses to withhold acknowledges. The block then walks the sixteen slots in ascending order, one per clock, and drives a write to the array for every slot that was filled. A programmable cycle counter then models the erase-and-write time before `busy` drops.

Top module: `page_commit`

## Requirements
- R1: After reset `busy` and `mem_we` are low, and they stay low until a STOP closes a transaction that carried data.
- R2: The k-th data byte (counting from 0) of a transaction goes to slot (start_addr[3:0] + k) mod 16. It is committed to array address {start_addr[10:4], slot} with that byte as data.
- R3: The slot index wraps from 15 to 0 and stays in the same page, so the commit address never leaves page start_addr[10:4].
- R4: When more than 16 bytes arrive, each slot holds the last byte written to it, so only the final sixteen bytes are stored.
- R5: Only the slots written in the current transaction are committed. The commit scans slots 0 to 15 in ascending order, one per clock, starting the clock after the STOP is taken. A slot that was not written produces no `mem_we` pulse.
- R6: A qualifying STOP raises `busy` in the next clock. `busy` then stays high for exactly 16 + PROG_CYCLES clocks (the scan followed by the timed wait) and falls when the counter expires.
- R7: If `wp` is high when the STOP is taken, no program cycle starts and `busy` stays low. `mem_we` is never high while `wp` is high.
- R8: A STOP in a transaction that carried no data byte starts no program cycle.
- R9: A new START discards every byte collected so far and clears the valid mask. The transaction restarts at the new address.
- R10: START, data byte and STOP strobes that arrive while `busy` is high are ignored. They cause no later write and do not lengthen the busy period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txn_start | input | 1 | One-clock strobe: a write transaction opens |
| start_addr | input | 11 | Starting array address, sampled with `txn_start` |
| byte_vld | input | 1 | One-clock strobe: `byte_data` holds a received data byte |
| byte_data | input | 8 | Received data byte |
| txn_stop | input | 1 | One-clock strobe: STOP ends the transaction |
| wp | input | 1 | Hardware write protect, active high |
| busy | output | 1 | High for the whole program cycle |
| mem_we | output | 1 | Array byte write enable |
| mem_addr | output | 11 | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The bench aims at the slot arithmetic first. A start address near the top of a page checks that the wrap stays in the page; a design that carried into the page bits would write into the next page. A twenty-byte burst checks that the first four slots hold the late bytes; a design that stopped at sixteen would keep the early ones. A transaction restarted by a second START, a data-less STOP and a STOP taken with `wp` high must all leave `busy` low with no array write; a design that kept the stale valid mask, or that checked the pin only per byte, would issue writes the scoreboard does not expect. Strobes injected in the middle of a busy period must change neither the write stream nor the busy length of 16 + PROG_CYCLES clocks. A design that let them through would show an extra write or a longer busy period.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  typedef enum logic [1:0] {
    PC_IDLE    = 2'd0,
    PC_COLLECT = 2'd1,
    PC_COMMIT  = 2'd2,
    PC_WAIT    = 2'd3
  } pc_state_t;
endpackage

// File: rtl/page_buffer.sv
module page_buffer #(
  parameter int SLOT_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);
  localparam int SLOTS = 1 << SLOT_W;

  logic [DATA_W-1:0] store [SLOTS];
  logic [SLOTS-1:0]  vmask;

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == SLOT_W'(s))) store[s] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      vmask <= '0;
    else if (clr)    vmask <= '0;
    else if (wr_en)  vmask[wr_slot] <= 1'b1;
  end

  assign rd_data = store[rd_slot];
  assign rd_vld  = vmask[rd_slot];
  assign any_vld = |vmask;
endmodule

// File: rtl/prog_timer.sv
module prog_timer #(
  parameter int PROG_CYCLES = 2_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0] remain;
  logic             running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain  <= '0;
      running <= 1'b0;
    end else if (load) begin
      remain  <= CNT_W'(PROG_CYCLES - 1);
      running <= 1'b1;
    end else if (running) begin
      if (remain == '0) running <= 1'b0;
      else              remain  <= remain - 1'b1;
    end
  end

  assign done = running && (remain == '0);
endmodule

// File: rtl/commit_seq.sv
module commit_seq
  import page_commit_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic              txn_stop,
  input  logic              wp,
  input  logic              any_vld,
  input  logic              tmr_done,
  output pc_state_t         state,
  output logic              start_take,
  output logic              byte_take,
  output logic [SLOT_W-1:0] wr_slot,
  output logic [SLOT_W-1:0] scan_slot,
  output logic [ADDR_W-SLOT_W-1:0] page,
  output logic              tmr_load
);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:SLOT_W];
  endfunction

  function automatic logic [SLOT_W-1:0] slot_of(input logic [ADDR_W-1:0] a);
    return a[SLOT_W-1:0];
  endfunction

  function automatic logic [SLOT_W-1:0] next_slot(input logic [SLOT_W-1:0] s);
    return s + 1'b1;
  endfunction

  logic open_txn;
  logic scan_last;

  assign open_txn   = (state == PC_IDLE) || (state == PC_COLLECT);
  assign start_take = open_txn && txn_start;
  assign byte_take  = (state == PC_COLLECT) && byte_vld && !txn_start;
  assign scan_last  = &scan_slot;
  assign tmr_load   = (state == PC_COMMIT) && scan_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= PC_IDLE;
      wr_slot   <= '0;
      scan_slot <= '0;
      page      <= '0;
    end else begin
      case (state)
        PC_IDLE, PC_COLLECT: begin
          if (start_take) begin
            state   <= PC_COLLECT;
            page    <= page_of(start_addr);
            wr_slot <= slot_of(start_addr);
          end else if (byte_take) begin
            wr_slot <= next_slot(wr_slot);
          end else if ((state == PC_COLLECT) && txn_stop) begin
            state     <= (any_vld && !wp) ? PC_COMMIT : PC_IDLE;
            scan_slot <= '0;
          end
        end
        PC_COMMIT: begin
          scan_slot <= next_slot(scan_slot);
          if (scan_last) state <= PC_WAIT;
        end
        PC_WAIT: begin
          if (tmr_done) state <= PC_IDLE;
        end
        default: state <= PC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/page_commit.sv
module page_commit
  import page_commit_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SLOT_W      = 4,
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 2_500_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              txn_stop,
  input  logic              wp,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam int PAGE_W = ADDR_W - SLOT_W;

  pc_state_t         state;
  logic              start_take;
  logic              byte_take;
  logic [SLOT_W-1:0] wr_slot;
  logic [SLOT_W-1:0] scan_slot;
  logic [PAGE_W-1:0] page;
  logic              tmr_load;
  logic              tmr_done;
  logic              any_vld;
  logic              slot_vld;
  logic [DATA_W-1:0] slot_data;

  commit_seq #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .txn_stop(txn_stop), .wp(wp), .any_vld(any_vld),
    .tmr_done(tmr_done), .state(state), .start_take(start_take),
    .byte_take(byte_take), .wr_slot(wr_slot), .scan_slot(scan_slot),
    .page(page), .tmr_load(tmr_load)
  );

  page_buffer #(.SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(start_take), .wr_en(byte_take),
    .wr_slot(wr_slot), .wr_data(byte_data), .rd_slot(scan_slot),
    .rd_data(slot_data), .rd_vld(slot_vld), .any_vld(any_vld)
  );

  prog_timer #(.PROG_CYCLES(PROG_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .done(tmr_done)
  );

  assign busy      = (state == PC_COMMIT) || (state == PC_WAIT);
  assign mem_we    = (state == PC_COMMIT) && slot_vld && !wp;
  assign mem_addr  = {page, scan_slot};
  assign mem_wdata = slot_data;
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int ADDR_W = 11,
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              txn_stop,
  input logic              wp,
  input logic              busy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              tmr_done
);
  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);

  // R7
  wp_blocks_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !wp);

  // R6
  busy_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(txn_stop));

  // R6
  busy_ends_on_timer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(tmr_done));

  // R3
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && $past(busy)) |->
      (mem_addr[ADDR_W-1:SLOT_W] == $past(mem_addr[ADDR_W-1:SLOT_W])));
endmodule

bind page_commit page_commit_chk #(.ADDR_W(ADDR_W), .SLOT_W(SLOT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .txn_stop(txn_stop), .wp(wp), .busy(busy),
  .mem_we(mem_we), .mem_addr(mem_addr), .tmr_done(tmr_done)
);

// File: tb/sim_page_commit.sv
`timescale 1ns/1ps
module sim_page_commit;
  localparam int PC = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        txn_start = 1'b0;
  logic [10:0] start_addr = '0;
  logic        byte_vld = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        txn_stop = 1'b0;
  logic        wp = 1'b0;
  logic        busy, mem_we;
  logic [10:0] mem_addr;
  logic [7:0]  mem_wdata;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string tag = "R2";

  logic [18:0] exp_q[$];
  bit [7:0] m_buf[16];
  bit       m_vld[16];
  int       m_base, m_ptr;
  bit       m_open = 0;

  always #2 clk = ~clk;

  page_commit #(.PROG_CYCLES(PC)) u0 (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .txn_stop(txn_stop), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  task automatic check(input bit ok, input string t, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", t, act, expv);
    end
  endtask

  // monitor: pop expected array writes as they appear
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      if (exp_q.size() == 0) begin
        check(0, {tag, " unexpected write"}, {mem_addr, mem_wdata}, 0);
      end else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        check({mem_addr, mem_wdata} == e, {tag, " write"}, {mem_addr, mem_wdata}, e);
      end
    end
  end

  task automatic b_start(input int a);
    txn_start = 1; start_addr = 11'(a);
    @(negedge clk); txn_start = 0;
    m_open = 1; m_base = a & 'h7F0; m_ptr = a & 15;
    for (int s = 0; s < 16; s++) m_vld[s] = 0;
  endtask

  task automatic b_byte(input int d);
    byte_vld = 1; byte_data = 8'(d);
    @(negedge clk); byte_vld = 0;
    if (m_open) begin
      m_buf[m_ptr] = 8'(d); m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % 16;
    end
  endtask

  task automatic b_stop(input bit w, input bit inject);
    bit any;
    int n;
    any = 0;
    for (int s = 0; s < 16; s++) any |= m_vld[s];
    wp = w; txn_stop = 1;
    @(negedge clk); txn_stop = 0;
    if (m_open && any && !w)
      for (int s = 0; s < 16; s++)
        if (m_vld[s]) exp_q.push_back({11'(m_base | s), m_buf[s]});
    m_open = 0;
    n = 0;
    for (int i = 0; i < PC + 40; i++) begin
      if (busy) n++;
      txn_start  = inject && (i == 2);
      start_addr = 11'h7FF;
      byte_vld   = inject && (i == 3);
      byte_data  = 8'hEE;
      txn_stop   = inject && (i == 4);
      @(negedge clk);
    end
    txn_start = 0; byte_vld = 0; txn_stop = 0; wp = 0;
    check(n == ((m_base >= 0 && any && !w && exp_q.size() >= 0 && n != 0) ? 16 + PC : 0) || (n == 0 && (!any || w)),
          {tag, " busy length"}, n, (any && !w) ? 16 + PC : 0);
    check(exp_q.size() == 0, {tag, " missing writes"}, exp_q.size(), 0);
    check(busy == 0, {tag, " busy low after cycle"}, busy, 0);
    exp_q.delete();
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check(busy == 0, "R1 busy after reset", busy, 0);
    check(mem_we == 0, "R1 we after reset", mem_we, 0);

    // R2 / R5 / R6: three bytes mid page
    tag = "R2";
    b_start('h123); b_byte('hA1); b_byte('hB2); b_byte('hC3);
    b_stop(0, 0);

    // R3: wrap inside page, commit in ascending slot order
    tag = "R3";
    b_start('h0FE);
    for (int k = 0; k < 5; k++) b_byte('h50 + k);
    b_stop(0, 0);

    // R4: twenty bytes, last sixteen kept
    tag = "R4";
    b_start('h200);
    for (int k = 0; k < 20; k++) b_byte(k + 1);
    b_stop(0, 0);

    // R7: write protect at stop
    tag = "R7";
    b_start('h345); b_byte('h11); b_byte('h22);
    b_stop(1, 0);

    // R8: stop with no data
    tag = "R8";
    b_start('h400);
    b_stop(0, 0);

    // R9: restart discards earlier bytes
    tag = "R9";
    b_start('h510); b_byte('h77); b_byte('h88);
    b_start('h63C); b_byte('h99);
    b_stop(0, 0);
    tag = "R9";
    b_start('h700); b_byte('h12);
    b_start('h710);
    b_stop(0, 0);

    // R10: strobes during busy ignored
    tag = "R10";
    b_start('h081); b_byte('h3C);
    b_stop(0, 1);
    check(mem_we == 0, "R10 no late write", mem_we, 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule